// File: doc/BRIEF.md
# Register-File Burst Load/Store Engine

This block moves a run of bytes between a byte-wide data memory and a bank of 32-bit registers. It handles four operations. A load copies memory into registers. A store copies register bytes into memory. Fill and zero write a range of register bytes to all-ones or all-zeros and never touch memory. Each operation is described by a first register, a first byte lane inside that register, a byte count and an opcode. Loads and stores also take a base register and an unsigned immediate offset. The engine walks the range one byte per cycle.

Successive bytes go to successive lanes, lane 0 being bits 7:0. When lane 3 has been used, the next byte goes to lane 0 of the following register. A partly covered register therefore keeps its other lanes. An optional null-address check lets a load or store whose effective address is zero abort and raise a trap in place of completing.

The memory has a single port and one cycle of read latency. The register bank has a read port with no latency and a write port with a byte enable for each lane. Both are outside the block.

The controller has six states:
- IDLE waits for start.
- BASE reads the base register and forms the address.
- LOAD keeps one memory read and one register write in flight each cycle.
- STORE moves one byte per cycle from a register to memory.
- FILL writes one byte per cycle of the constant into the registers.
- DONE signals completion.

The transitions are:
- IDLE→BASE for a load or store.
- IDLE→FILL for fill or zero.
- IDLE→DONE for a zero count.
- BASE→LOAD or BASE→STORE.
- BASE→DONE when the null trap fires.
- LOAD, STORE or FILL→DONE after the last byte.
- DONE→IDLE.

Top module: `bre_engine`

## Requirements
- R1: While reset is held and directly after it, busy, done, trap, rf_we, mem_re and mem_we are all low.
- R2: start is taken only while busy is low. busy is high from the next cycle through the cycle in which done is high, and done lasts exactly one cycle. A start raised while busy is high has no effect.
- R3: The effective address is the low AW bits of the base register plus the zero-extended imm_off, modulo 2^AW. Byte n of the transfer uses memory address (effective address + n) modulo 2^AW.
- R4: op 0 (load) writes memory byte n into register (reg_first + (lane_first + n)/4) mod NREG, at lane (lane_first + n) mod 4. Lane k is bits 8k+7:8k.
- R5: A load changes no register lane outside the requested byte range. A partly covered first or last register keeps its other lanes.
- R6: op 1 (store) writes exactly count memory bytes, taking byte n from the register and lane that R4 maps it to. No other memory byte changes.
- R7: op 2 (fill) sets every byte of the mapped register range to 0xFF, and op 3 (zero) sets it to 0x00. Neither accesses memory.
- R8: A register index past NREG-1 wraps to register 0.
- R9: The null check applies to loads and stores with a non-zero count.
  - With null_chk_en low, an effective address of 0 is handled like any other address.
  - With null_chk_en high and an effective address of 0, the operation makes no memory or register access. trap rises in the done cycle, with trap_size equal to the count and trap_addr equal to 0.
  - trap stays high until the next accepted start.
- R10: A count of 0 completes with no access. A count above MAX_BYTES (124) is handled as MAX_BYTES.
- R11: Counting clock edges after the edge that takes start, done is high after N edges for fill and zero, N+1 for a store, N+2 for a load, 1 for a null trap and 0 for a zero count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (sampled while idle) |
| op | input | 2 | 0 load, 1 store, 2 fill, 3 zero |
| reg_first | input | RIW | First register of the range |
| lane_first | input | 2 | First byte lane inside reg_first |
| base_sel | input | RIW | Register that holds the base address |
| imm_off | input | IMMW | Unsigned byte offset added to the base |
| byte_cnt | input | CW | Number of bytes to move |
| null_chk_en | input | 1 | Enable the address-zero trap |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| trap | output | 1 | Null-address trap raised by the last operation |
| trap_size | output | CW | Byte count of the trapped access |
| trap_addr | output | AW | Address of the trapped access |
| rf_idx | output | RIW | Register bank index (read and write) |
| rf_rdata | input | 32 | Register bank read data, no latency |
| rf_we | output | 1 | Register bank write strobe |
| rf_be | output | 4 | Register bank byte-lane enables |
| rf_wdata | output | 32 | Register bank write data |
| mem_addr | output | AW | Memory byte address |
| mem_re | output | 1 | Memory read strobe, data valid one cycle later |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte |

## Verification
The bench covers several risky cases:
- **7-byte load into a cleared range.** A design that wrote whole words would clear or corrupt lane 3 of the second register.
- **Single-byte and four-byte stores inside a field of 0xFF.** A design without a proper write mask would overwrite the neighbouring bytes.
- **Load with a lane offset, and a zero spanning the top register.** These catch off-by-one lane arithmetic and missing register-index wrap.
- **Null check.** The same zero-address load is issued with the check off and then on. A check tied the wrong way would either abort normal accesses or let the trapped access still write.
- **Latency, zero count and over-size count.** Measuring latency exposes a load pipeline that drops or repeats the last byte. The zero and over-size counts expose missing clamping.
- **Start while busy.** A start pulse in the middle of a long fill exposes a controller that re-arms during an operation.

// File: rtl/bre_pkg.sv
package bre_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_FILL  = 2'd2,
        OP_ZERO  = 2'd3
    } bre_op_e;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_BASE  = 3'd1,
        S_LOAD  = 3'd2,
        S_STORE = 3'd3,
        S_FILL  = 3'd4,
        S_DONE  = 3'd5
    } bre_state_e;

endpackage

// File: rtl/bre_addr_gen.sv
// Effective address formation, null detection and per-byte address.
module bre_addr_gen #(
    parameter int AW   = 10,
    parameter int IMMW = 8,
    parameter int CW   = 7
) (
    input  logic [AW-1:0]   base_lo,
    input  logic [IMMW-1:0] imm,
    input  logic [AW-1:0]   ea_base,
    input  logic [CW-1:0]   pos,
    output logic [AW-1:0]   ea_new,
    output logic            ea_null,
    output logic [AW-1:0]   byte_addr
);
    assign ea_new    = base_lo + AW'(imm);
    assign ea_null   = (ea_new == '0);
    assign byte_addr = ea_base + AW'(pos);
endmodule

// File: rtl/bre_lane_map.sv
// Maps a byte position of the transfer to a register index and lane.
module bre_lane_map #(
    parameter int NREG = 32,
    parameter int CW   = 7,
    localparam int RIW = $clog2(NREG)
) (
    input  logic [RIW-1:0] reg_base,
    input  logic [1:0]     lane_base,
    input  logic [CW-1:0]  pos,
    output logic [RIW-1:0] reg_idx,
    output logic [1:0]     lane
);
    localparam int PW = CW + 1;

    logic [PW-1:0] abs_pos;

    assign abs_pos = PW'(pos) + PW'(lane_base);
    assign lane    = abs_pos[1:0];
    // NREG is a power of two, so truncation gives the wrap to register 0
    assign reg_idx = reg_base + RIW'(abs_pos >> 2);
endmodule

// File: rtl/bre_byte_lane.sv
// Lane selection from a word, one-hot lane enables and byte replication.
module bre_byte_lane #(
    parameter int LANES = 4,
    localparam int LW   = $clog2(LANES)
) (
    input  logic [8*LANES-1:0] word_in,
    input  logic [LW-1:0]      lane,
    input  logic               en,
    input  logic [7:0]         fill,
    output logic [7:0]         byte_out,
    output logic [LANES-1:0]   be,
    output logic [8*LANES-1:0] word_out
);
    assign byte_out = word_in[8*lane +: 8];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign be[g]            = en && (lane == LW'(g));
        assign word_out[8*g +: 8] = fill;
    end
endmodule

// File: rtl/bre_engine.sv
module bre_engine
    import bre_pkg::*;
#(
    parameter int NREG      = 32,
    parameter int AW        = 10,
    parameter int IMMW      = 8,
    parameter int MAX_BYTES = 124,
    localparam int RIW      = $clog2(NREG),
    localparam int CW       = $clog2(MAX_BYTES + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [1:0]      op,
    input  logic [RIW-1:0]  reg_first,
    input  logic [1:0]      lane_first,
    input  logic [RIW-1:0]  base_sel,
    input  logic [IMMW-1:0] imm_off,
    input  logic [CW-1:0]   byte_cnt,
    input  logic            null_chk_en,
    output logic            busy,
    output logic            done,
    output logic            trap,
    output logic [CW-1:0]   trap_size,
    output logic [AW-1:0]   trap_addr,
    output logic [RIW-1:0]  rf_idx,
    input  logic [31:0]     rf_rdata,
    output logic            rf_we,
    output logic [3:0]      rf_be,
    output logic [31:0]     rf_wdata,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_re,
    output logic            mem_we,
    output logic [7:0]      mem_wdata,
    input  logic [7:0]      mem_rdata
);
    localparam logic [CW-1:0] MAXC = CW'(MAX_BYTES);

    bre_state_e      state_q, state_d;
    bre_op_e         op_q;
    logic [RIW-1:0]  reg_q, base_q;
    logic [1:0]      lane_q;
    logic [IMMW-1:0] imm_q;
    logic [CW-1:0]   cnt_q, pos_q, pend_pos_q, tsize_q;
    logic            nchk_q, pend_q, trap_q;
    logic [AW-1:0]   ea_q, taddr_q;

    logic [CW-1:0]   cnt_in, last_pos, map_pos;
    logic            issue, ea_null, trap_hit, lane_en;
    logic [AW-1:0]   ea_new, byte_addr;
    logic [RIW-1:0]  map_reg;
    logic [1:0]      map_lane;
    logic [7:0]      pick_byte, fill_byte;
    logic [31:0]     fill_word;
    logic [3:0]      lane_be;

    assign cnt_in   = (byte_cnt > MAXC) ? MAXC : byte_cnt;
    assign last_pos = cnt_q - CW'(1);
    assign issue    = (state_q == S_LOAD) && (pos_q < cnt_q);
    assign trap_hit = nchk_q && ea_null;
    assign map_pos  = (state_q == S_LOAD) ? pend_pos_q : pos_q;
    assign lane_en  = rf_we;
    assign fill_byte = (state_q == S_LOAD) ? mem_rdata :
                       ((op_q == OP_FILL) ? 8'hFF : 8'h00);

    bre_addr_gen #(.AW(AW), .IMMW(IMMW), .CW(CW)) u_addr (
        .base_lo  (rf_rdata[AW-1:0]),
        .imm      (imm_q),
        .ea_base  (ea_q),
        .pos      (pos_q),
        .ea_new   (ea_new),
        .ea_null  (ea_null),
        .byte_addr(byte_addr)
    );

    bre_lane_map #(.NREG(NREG), .CW(CW)) u_map (
        .reg_base (reg_q),
        .lane_base(lane_q),
        .pos      (map_pos),
        .reg_idx  (map_reg),
        .lane     (map_lane)
    );

    bre_byte_lane #(.LANES(4)) u_lane (
        .word_in (rf_rdata),
        .lane    (map_lane),
        .en      (lane_en),
        .fill    (fill_byte),
        .byte_out(pick_byte),
        .be      (lane_be),
        .word_out(fill_word)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    if (cnt_in == '0)
                        state_d = S_DONE;
                    else if (bre_op_e'(op) == OP_LOAD || bre_op_e'(op) == OP_STORE)
                        state_d = S_BASE;
                    else
                        state_d = S_FILL;
                end
            end
            S_BASE: begin
                if (trap_hit)
                    state_d = S_DONE;
                else if (op_q == OP_LOAD)
                    state_d = S_LOAD;
                else
                    state_d = S_STORE;
            end
            S_LOAD:  if (pend_q && pend_pos_q == last_pos) state_d = S_DONE;
            S_STORE: if (pos_q == last_pos) state_d = S_DONE;
            S_FILL:  if (pos_q == last_pos) state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register and operation context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            op_q       <= OP_LOAD;
            reg_q      <= '0;
            base_q     <= '0;
            lane_q     <= '0;
            imm_q      <= '0;
            cnt_q      <= '0;
            nchk_q     <= 1'b0;
            pos_q      <= '0;
            pend_q     <= 1'b0;
            pend_pos_q <= '0;
            ea_q       <= '0;
            trap_q     <= 1'b0;
            tsize_q    <= '0;
            taddr_q    <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        op_q   <= bre_op_e'(op);
                        reg_q  <= reg_first;
                        lane_q <= lane_first;
                        base_q <= base_sel;
                        imm_q  <= imm_off;
                        cnt_q  <= cnt_in;
                        nchk_q <= null_chk_en;
                        pos_q  <= '0;
                        pend_q <= 1'b0;
                        trap_q <= 1'b0;
                    end
                end
                S_BASE: begin
                    ea_q <= ea_new;
                    if (trap_hit) begin
                        trap_q  <= 1'b1;
                        tsize_q <= cnt_q;
                        taddr_q <= ea_new;
                    end
                end
                S_LOAD: begin
                    if (issue) pos_q <= pos_q + CW'(1);
                    pend_q     <= issue;
                    pend_pos_q <= pos_q;
                end
                S_STORE, S_FILL: pos_q <= pos_q + CW'(1);
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q != S_IDLE);
        done      = (state_q == S_DONE);
        trap      = trap_q;
        trap_size = tsize_q;
        trap_addr = taddr_q;
        rf_idx    = map_reg;
        rf_we     = 1'b0;
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        unique case (state_q)
            S_BASE:  rf_idx = base_q;
            S_LOAD: begin
                rf_we  = pend_q;
                mem_re = issue;
            end
            S_STORE: mem_we = 1'b1;
            S_FILL:  rf_we  = 1'b1;
            default: ;
        endcase
        rf_be     = lane_be;
        rf_wdata  = fill_word;
        mem_addr  = byte_addr;
        mem_wdata = pick_byte;
    end
endmodule

// File: rtl/bre_engine_chk.sv
module bre_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic       trap,
    input logic       rf_we,
    input logic [3:0] rf_be,
    input logic       mem_re,
    input logic       mem_we
);
    p_busy_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_done_then_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!busy && !done));

    p_strobe_in_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we || mem_re || mem_we) |-> busy);

    p_single_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> ($countones(rf_be) == 1));

    p_store_alone_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (!rf_we && !mem_re));

    p_trap_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trap) |-> done);

    p_trap_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (trap && !busy && !start) |=> trap);
endmodule

bind bre_engine bre_engine_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done),
    .trap  (trap),
    .rf_we (rf_we),
    .rf_be (rf_be),
    .mem_re(mem_re),
    .mem_we(mem_we)
);

// File: tb/bre_engine_tb.sv
module bre_engine_tb;
    localparam int NREG = 32;
    localparam int AW   = 10;
    localparam int IMMW = 8;
    localparam int MAXB = 124;
    localparam int RIW  = $clog2(NREG);
    localparam int CW   = $clog2(MAXB + 1);
    localparam int MEM  = 1 << AW;

    logic clk, rst_n, start, null_chk_en;
    logic [1:0] op_i, lane_first;
    logic [RIW-1:0] reg_first, base_sel, rf_idx;
    logic [IMMW-1:0] imm_off;
    logic [CW-1:0] byte_cnt, trap_size;
    logic busy, done, trap, rf_we, mem_re, mem_we;
    logic [AW-1:0] trap_addr, mem_addr;
    logic [31:0] rf_rdata, rf_wdata;
    logic [3:0] rf_be;
    logic [7:0] mem_wdata, mem_rdata;

    logic [7:0]  mem [MEM];
    logic [31:0] rf  [NREG];
    logic [7:0]  exp_mem [MEM];
    logic [31:0] exp_rf  [NREG];

    logic bw_mem, bw_rf;
    logic [AW-1:0] bw_addr;
    logic [7:0] bw_byte;
    logic [RIW-1:0] bw_ridx;
    logic [31:0] bw_word;

    int checks = 0;
    int errs   = 0;

    bre_engine #(.NREG(NREG), .AW(AW), .IMMW(IMMW), .MAX_BYTES(MAXB)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op_i),
        .reg_first(reg_first), .lane_first(lane_first), .base_sel(base_sel),
        .imm_off(imm_off), .byte_cnt(byte_cnt), .null_chk_en(null_chk_en),
        .busy(busy), .done(done), .trap(trap), .trap_size(trap_size),
        .trap_addr(trap_addr), .rf_idx(rf_idx), .rf_rdata(rf_rdata),
        .rf_we(rf_we), .rf_be(rf_be), .rf_wdata(rf_wdata),
        .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    // external storage models: synchronous byte memory, register bank
    always @(posedge clk) begin
        if (bw_mem) mem[bw_addr] <= bw_byte;
        if (bw_rf)  rf[bw_ridx]  <= bw_word;
        if (mem_re) mem_rdata <= mem[mem_addr];
        if (mem_we) mem[mem_addr] <= mem_wdata;
        if (rf_we)
            for (int l = 0; l < 4; l++)
                if (rf_be[l]) rf[rf_idx][8*l +: 8] <= rf_wdata[8*l +: 8];
    end
    assign rf_rdata = rf[rf_idx];

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired act=hung exp=finished");
        $display("CHECKS %0d ERRORS %0d", checks + 1, errs + 1);
        $finish;
    end

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    // reference model: applies the operation to the expected arrays
    task automatic ref_op(input int op, input int rs, input int ln, input int br,
                          input int imm, input int cnt, input bit nchk,
                          output int lat, output bit tr, output int tsz, output int tad);
        int n;
        logic [AW-1:0] ea, a;
        n   = (cnt > MAXB) ? MAXB : cnt;
        ea  = exp_rf[br][AW-1:0] + AW'(imm);
        tr  = 1'b0; tsz = 0; tad = 0;
        if (n == 0) lat = 0;
        else if (op <= 1 && nchk && ea == '0) begin
            tr = 1'b1; lat = 1; tsz = n; tad = int'(ea);
        end else begin
            lat = (op >= 2) ? n : ((op == 1) ? n + 1 : n + 2);
            for (int k = 0; k < n; k++) begin
                int ab, r, l;
                ab = ln + k;
                r  = (rs + ab / 4) % NREG;
                l  = ab % 4;
                a  = ea + AW'(k);
                case (op)
                    0: exp_rf[r][8*l +: 8] = exp_mem[a];
                    1: exp_mem[a] = exp_rf[r][8*l +: 8];
                    2: exp_rf[r][8*l +: 8] = 8'hFF;
                    default: exp_rf[r][8*l +: 8] = 8'h00;
                endcase
            end
        end
    endtask

    task automatic run_op(input int op, input int rs, input int ln, input int br,
                          input int imm, input int cnt, input bit nchk, input bit poke);
        int elat, etsz, etad, lat, badm, badr;
        bit etr;
        string dtag;
        ref_op(op, rs, ln, br, imm, cnt, nchk, elat, etr, etsz, etad);
        dtag = (op == 0) ? "R4" : ((op == 1) ? "R6" : "R7");
        @(negedge clk);
        start = 1'b1; op_i = 2'(op); reg_first = RIW'(rs); lane_first = 2'(ln);
        base_sel = RIW'(br); imm_off = IMMW'(imm); byte_cnt = CW'(cnt);
        null_chk_en = nchk;
        @(posedge clk);
        @(negedge clk);
        lat = 0;
        while (!done && lat < 600) begin
            start = poke && (lat == 2);   // R2: start while busy must be ignored
            if (poke) op_i = 2'd1;
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        chk("R11", "latency", 64'(lat), 64'(elat));
        chk("R9", "trap at done", 64'(trap), 64'(etr));
        if (etr) begin
            chk("R9", "trap_size", 64'(trap_size), 64'(etsz));
            chk("R9", "trap_addr", 64'(trap_addr), 64'(etad));
        end
        @(negedge clk);
        chk("R2", "busy/done after done", {62'd0, busy, done}, 64'd0);
        if (etr) chk("R9", "trap held", 64'(trap), 64'd1);
        badm = -1; badr = -1;
        for (int i = 0; i < MEM; i++) if (badm < 0 && mem[i] !== exp_mem[i]) badm = i;
        for (int i = 0; i < NREG; i++) if (badr < 0 && rf[i] !== exp_rf[i]) badr = i;
        if (badm < 0) chk(dtag, "memory image", 64'd0, 64'd0);
        else chk(dtag, $sformatf("mem[%0h]", badm), 64'(mem[badm]), 64'(exp_mem[badm]));
        if (badr < 0) chk(dtag, "register image", 64'd0, 64'd0);
        else chk(dtag, $sformatf("rf[%0d]", badr), 64'(rf[badr]), 64'(exp_rf[badr]));
    endtask

    initial begin
        void'($urandom(32'h5EED_0B1E));
        rst_n = 1'b0; start = 1'b0; op_i = '0; reg_first = '0; lane_first = '0;
        base_sel = '0; imm_off = '0; byte_cnt = '0; null_chk_en = 1'b0;
        bw_mem = 1'b0; bw_rf = 1'b0; bw_addr = '0; bw_byte = '0; bw_ridx = '0; bw_word = '0;

        // preload storage while reset is held
        for (int i = 0; i < MEM; i++) begin
            if (i >= 'h100 && i < 'h108) exp_mem[i] = 8'(8'h01 + 8'h22 * (i - 'h100));
            else if (i >= 'h108 && i < 'h110) exp_mem[i] = 8'hFF;
            else exp_mem[i] = 8'($urandom);
            @(negedge clk);
            bw_mem = 1'b1; bw_addr = AW'(i); bw_byte = exp_mem[i];
        end
        for (int i = 0; i < NREG; i++) begin
            exp_rf[i] = (i == 0) ? 32'h100 : ((i == 1) ? 32'h0 :
                        ((i == 5) ? 32'h11 : $urandom));
            @(negedge clk);
            bw_mem = 1'b0; bw_rf = 1'b1; bw_ridx = RIW'(i); bw_word = exp_rf[i];
        end
        @(negedge clk);
        bw_rf = 1'b0;
        chk("R1", "outputs in reset",
            {58'd0, busy, done, trap, rf_we, mem_re, mem_we}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "outputs after reset",
            {58'd0, busy, done, trap, rf_we, mem_re, mem_we}, 64'd0);

        // fill then zero a 16-byte range of four registers
        run_op(2, 20, 0, 0, 0, 16, 0, 0);
        chk("R7", "fill r23", 64'(rf[23]), 64'hFFFF_FFFF);
        run_op(3, 20, 0, 0, 0, 16, 0, 0);
        chk("R7", "zero r20", 64'(rf[20]), 64'h0);

        // 7-byte load: lane 3 of the second register must stay zero
        run_op(0, 20, 0, 0, 0, 7, 0, 0);
        chk("R4", "load r20", 64'(rf[20]), 64'h6745_2301);
        chk("R5", "partial r21", 64'(rf[21]), 64'h00CD_AB89);

        // narrow stores inside a field of 0xFF
        run_op(1, 5, 0, 0, 9, 1, 0, 0);
        run_op(1, 5, 0, 0, 12, 4, 0, 0);
        run_op(0, 20, 0, 0, 0, 16, 0, 0);
        chk("R6", "masked store r22", 64'(rf[22]), 64'hFFFF_11FF);
        chk("R3", "offset store r23", 64'(rf[23]), 64'h0000_0011);

        // null check off, then on for load and store, then on with non-zero address
        run_op(0, 24, 0, 1, 0, 4, 0, 0);
        run_op(0, 12, 0, 1, 0, 4, 1, 0);
        run_op(1, 12, 0, 1, 0, 4, 1, 0);
        run_op(0, 12, 0, 1, 1, 4, 1, 0);

        // starting lane 3
        run_op(0, 8, 3, 0, 0, 5, 0, 0);
        chk("R4", "lane-offset r9", 64'(rf[9]), 64'h8967_4523);
        chk("R4", "lane-offset r8 b3", 64'(rf[8][31:24]), 64'h01);

        // zero count, over-size count (with a start pulse while busy)
        run_op(2, 2, 0, 0, 0, 0, 0, 0);
        run_op(2, 0, 0, 0, 0, 127, 0, 1);
        chk("R10", "clamped fill kept r31", 64'(rf[31]), 64'(exp_rf[31]));

        // register index wrap
        run_op(3, 30, 2, 0, 0, 12, 0, 0);
        chk("R8", "wrap r0", 64'(rf[0]), 64'h0);
        chk("R8", "wrap r1", 64'(rf[1]), 64'hFFFF_0000);

        // constrained random operations
        for (int t = 0; t < 60; t++) begin
            int c;
            c = ($urandom % 8 == 0) ? int'($urandom % 128) : int'(1 + $urandom % 20);
            run_op(int'($urandom % 4), int'($urandom % NREG), int'($urandom % 4),
                   int'($urandom % NREG), int'($urandom % 256), c,
                   bit'($urandom % 2), 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end
endmodule